// File: doc/BRIEF.md
# Escalating Three-Stage Watchdog Timer

This block is a per-core watchdog that escalates when software stops servicing it. A configuration write supplies a 16-bit length and a 2-bit mode. The length forms the upper part of a wider down-counter whose low bits always reload as zero. The counter steps once every `DIVISOR` clocks. Each time a period runs out without a service pulse, the block moves one stage further: first an interrupt, then a non-maskable interrupt, then a soft-reset request. The mode value limits how far this escalation may go.

Software services the block with a one-cycle poke. A poke reloads the full period and returns all three outputs to low. The live counter value is always visible on an output port. Software can poll it, for example to find out how much time remains before the reset request appears.

Top module: `wdt3_core`

## Requirements
- R1: After reset the count output is 0, the mode is off, and the interrupt, NMI and soft-reset outputs are low.
- R2: A configuration write stores the length and mode. It loads the count with the length in the upper 16 bits and zero in the low 8 bits, returns escalation to its first stage, and drops every output.
- R3: While the block is enabled, the count falls by exactly one every `DIVISOR` clocks.
- R4: One period is length×256×`DIVISOR` clocks. The first unserviced expiry raises the interrupt on exactly the clock that ends the period, and the count then reloads to length×256.
- R5: Outputs escalate in a fixed order. The second unserviced expiry adds the NMI and the third adds the soft-reset request. Every raised output stays high until a poke or a configuration write clears it.
- R6: The mode field is encoded as follows: 0 = off, 1 = interrupt only, 2 = interrupt and NMI, 3 = all three stages. A stage beyond the programmed mode is never entered, however many periods expire.
- R7: Mode 0, or a length of 0, stops the block. The count holds its loaded value and no output is raised.
- R8: A poke reloads the count from the stored length, returns escalation to the first stage, and clears every output.
- R9: When a poke and an expiry fall on the same clock, the poke wins. No stage is entered, and the next expiry comes one full period later.
- R10: When a configuration write and a poke fall on the same clock, the count reloads from the newly written length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | One-cycle configuration write strobe |
| cfg_len_i | input | LEN_W (16) | Period length, upper bits of the count |
| cfg_mode_i | input | 2 | Escalation mode: 0 off, 1 irq, 2 irq+NMI, 3 all |
| poke_i | input | 1 | One-cycle service pulse |
| count_o | output | LEN_W+LOW_W (24) | Current counter value |
| irq_o | output | 1 | Stage-one interrupt, level |
| nmi_o | output | 1 | Stage-two non-maskable interrupt, level |
| srst_o | output | 1 | Stage-three soft-reset request, level |

## Verification
Two kinds of event can land on the same clock: a service poke and a period expiry. The bench lets the counter run until one clock before the expiry edge. It then drives the poke so that the poke is sampled on that same edge. The result counts as correct only if the interrupt stays low, the count reads the full reload value, and the interrupt then rises exactly one whole period later. The bench also lands a configuration write and a poke on one edge, and checks that the count reloads from the new length.

// File: rtl/wdt3_pkg.sv
package wdt3_pkg;

    // Escalation stage reached; the numeric order is the escalation order.
    typedef enum logic [1:0] {
        ST_RUN = 2'd0,
        ST_IRQ = 2'd1,
        ST_NMI = 2'd2,
        ST_RST = 2'd3
    } stage_e;

    // Highest stage a mode permits equals its numeric value.
    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_IRQ     = 2'd1,
        MODE_IRQ_NMI = 2'd2,
        MODE_FULL    = 2'd3
    } mode_e;

endpackage

// File: rtl/wdt3_prescaler.sv
module wdt3_prescaler #(
    parameter int DIVISOR = 256,
    localparam int PW = $clog2(DIVISOR)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       at_last;

    assign at_last = (st_q.pre == PW'(DIVISOR - 1));
    assign tick_o  = run_i && at_last && !restart_i;

    always_comb begin
        st_d = st_q;
        if (restart_i || !run_i) begin
            st_d.pre = '0;
        end else if (at_last) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.pre) < DIVISOR); // R3
    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> st_q.pre == '0); // R8

endmodule

// File: rtl/wdt3_decrementer.sv
module wdt3_decrementer #(
    parameter int LEN_W = 16,
    parameter int LOW_W = 8,
    localparam int CW = LEN_W + LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [LEN_W-1:0] load_len_i,
    output logic [CW-1:0]    count_o,
    output logic             expire_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } dec_state_t;

    dec_state_t    st_d, st_q;
    logic [CW-1:0] reload_val;

    assign reload_val = {load_len_i, {LOW_W{1'b0}}};
    assign count_o    = st_q.cnt;

    always_comb begin
        st_d     = st_q;
        expire_o = 1'b0;
        if (restart_i) begin
            st_d.cnt = reload_val;
        end else if (tick_i && st_q.cnt != '0) begin
            if (st_q.cnt == CW'(1)) begin
                expire_o = 1'b1;
                st_d.cnt = reload_val;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !restart_i && st_q.cnt > CW'(1)) |=> st_q.cnt == $past(st_q.cnt) - CW'(1)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !restart_i) |=> $stable(st_q.cnt)); // R7
    AST_RELOAD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i || expire_o) |=> st_q.cnt[LOW_W-1:0] == '0); // R2

endmodule

// File: rtl/wdt3_stage_seq.sv
module wdt3_stage_seq
    import wdt3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart_i,
    input  logic  expire_i,
    input  mode_e mode_i,
    output logic  irq_o,
    output logic  nmi_o,
    output logic  srst_o
);

    typedef struct packed {
        stage_e stage;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [2:0] level;

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.stage = ST_RUN;
        end else if (expire_i && (2'(st_q.stage) < 2'(mode_i))) begin
            st_d.stage = stage_e'(2'(st_q.stage) + 2'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{stage: ST_RUN};
        end else begin
            st_q <= st_d;
        end
    end

    // Output i is high once stage i+1 has been reached.
    for (genvar gi = 0; gi < 3; gi++) begin : g_level
        assign level[gi] = (2'(st_q.stage) > 2'(gi));
    end

    assign irq_o  = level[0];
    assign nmi_o  = level[1];
    assign srst_o = level[2];

    AST_STAGE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        2'(st_q.stage) <= 2'(mode_i)); // R6
    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage != $past(st_q.stage)) |->
            (st_q.stage == ST_RUN || 2'(st_q.stage) == 2'($past(st_q.stage)) + 2'd1)); // R5
    AST_POKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> st_q.stage == ST_RUN); // R9
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart_i && !expire_i) |=> $stable(st_q.stage)); // R5

endmodule

// File: rtl/wdt3_core.sv
module wdt3_core
    import wdt3_pkg::*;
#(
    parameter int DIVISOR = 256,
    parameter int LEN_W   = 16,
    parameter int LOW_W   = 8,
    localparam int CW     = LEN_W + LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic             poke_i,
    output logic [CW-1:0]    count_o,
    output logic             irq_o,
    output logic             nmi_o,
    output logic             srst_o
);

    typedef struct packed {
        logic [LEN_W-1:0] len;
        mode_e            mode;
    } cfg_state_t;

    cfg_state_t       cfg_d, cfg_q;
    logic             run;
    logic             restart;
    logic             tick;
    logic             expire;
    logic [LEN_W-1:0] load_len;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_wr_i) begin
            cfg_d.len  = cfg_len_i;
            cfg_d.mode = mode_e'(cfg_mode_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{len: '0, mode: MODE_OFF};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run      = (cfg_q.mode != MODE_OFF) && (cfg_q.len != '0);
    assign restart  = cfg_wr_i || poke_i;
    assign load_len = cfg_wr_i ? cfg_len_i : cfg_q.len;

    wdt3_prescaler #(
        .DIVISOR (DIVISOR)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (restart),
        .tick_o    (tick)
    );

    wdt3_decrementer #(
        .LEN_W (LEN_W),
        .LOW_W (LOW_W)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .restart_i  (restart),
        .load_len_i (load_len),
        .count_o    (count_o),
        .expire_o   (expire)
    );

    wdt3_stage_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (restart),
        .expire_i  (expire),
        .mode_i    (cfg_q.mode),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o),
        .srst_o    (srst_o)
    );

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> count_o == {$past(cfg_len_i), {LOW_W{1'b0}}}); // R2
    AST_POKE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (poke_i && !cfg_wr_i) |=> (count_o == {$past(cfg_q.len), {LOW_W{1'b0}}} && !irq_o)); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.mode == MODE_OFF) |-> !irq_o); // R7

endmodule

// File: tb/wdt3_core_tb.sv
module wdt3_core_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int LEN_W      = 16;
    localparam int LOW_W      = 8;
    localparam int CW         = LEN_W + LOW_W;
    localparam int NVEC       = 10;

    typedef struct packed {
        logic [15:0] len;
        logic [1:0]  mode;
        logic [2:0]  periods;
        logic        early;
        logic [2:0]  exp;   // {irq, nmi, srst}
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{len: 16'd1, mode: 2'd3, periods: 3'd1, early: 1'b1, exp: 3'b000},
        '{len: 16'd1, mode: 2'd3, periods: 3'd1, early: 1'b0, exp: 3'b100},
        '{len: 16'd1, mode: 2'd3, periods: 3'd2, early: 1'b1, exp: 3'b100},
        '{len: 16'd1, mode: 2'd3, periods: 3'd2, early: 1'b0, exp: 3'b110},
        '{len: 16'd1, mode: 2'd3, periods: 3'd3, early: 1'b1, exp: 3'b110},
        '{len: 16'd1, mode: 2'd3, periods: 3'd3, early: 1'b0, exp: 3'b111},
        '{len: 16'd1, mode: 2'd1, periods: 3'd3, early: 1'b0, exp: 3'b100},
        '{len: 16'd1, mode: 2'd2, periods: 3'd3, early: 1'b0, exp: 3'b110},
        '{len: 16'd2, mode: 2'd2, periods: 3'd2, early: 1'b0, exp: 3'b110},
        '{len: 16'd2, mode: 2'd3, periods: 3'd1, early: 1'b1, exp: 3'b000}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [LEN_W-1:0] cfg_len = '0;
    logic [1:0]       cfg_mode = 2'd0;
    logic             poke = 1'b0;
    logic [CW-1:0]    count;
    logic             irq, nmi, srst;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdt3_core #(
        .DIVISOR (DIV),
        .LEN_W   (LEN_W),
        .LOW_W   (LOW_W)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_i   (cfg_wr),
        .cfg_len_i  (cfg_len),
        .cfg_mode_i (cfg_mode),
        .poke_i     (poke),
        .count_o    (count),
        .irq_o      (irq),
        .nmi_o      (nmi),
        .srst_o     (srst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(input int len, input int mode);
        cfg_wr   = 1'b1;
        cfg_len  = LEN_W'(len);
        cfg_mode = 2'(mode);
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic do_poke();
        poke = 1'b1;
        step(1);
        poke = 1'b0;
    endtask

    function automatic int period(input int len);
        return len * 256 * DIV;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 3 + 1);
        // R1: reset state
        check("R1 count", 32'(count), 32'd0);
        check("R1 outputs", 32'({irq, nmi, srst}), 32'd0);
        rst_n = 1'b1;
        step(50);
        check("R1 idle after reset", 32'({irq, nmi, srst}), 32'd0);

        // R4 R5 R6: table walk, one fresh configuration per row
        for (int i = 0; i < NVEC; i++) begin
            int wait_n;
            write_cfg(int'(VECS[i].len), int'(VECS[i].mode));
            check("R2 load", 32'(count), 32'(VECS[i].len) << 8);
            wait_n = int'(VECS[i].periods) * period(int'(VECS[i].len)) - int'(VECS[i].early);
            step(wait_n);
            check("R5 R6 stage outputs", 32'({irq, nmi, srst}), 32'(VECS[i].exp));
            check("R4 count at edge", 32'(count),
                  VECS[i].early ? 32'd1 : (32'(VECS[i].len) << 8));
        end

        // R3: count steps by one every DIV clocks
        write_cfg(2, 3);
        check("R3 start", 32'(count), 32'd512);
        step(DIV - 1);
        check("R3 before step", 32'(count), 32'd512);
        step(1);
        check("R3 first step", 32'(count), 32'd511);
        step(DIV);
        check("R3 second step", 32'(count), 32'd510);

        // R8: poke before expiry keeps outputs low
        write_cfg(1, 3);
        step(period(1) - 10);
        do_poke();
        check("R8 poke reload", 32'(count), 32'd256);
        step(20);
        check("R8 no irq after poke", 32'(irq), 32'd0);

        // R8: poke clears raised outputs
        write_cfg(1, 3);
        step(2 * period(1));
        check("R8 pre-poke levels", 32'({irq, nmi, srst}), 32'b110);
        do_poke();
        check("R8 cleared", 32'({irq, nmi, srst}), 32'd0);
        check("R8 count reload", 32'(count), 32'd256);

        // R9: poke and expiry on the same edge
        write_cfg(1, 3);
        step(period(1) - 1);
        check("R9 pre-edge count", 32'(count), 32'd1);
        do_poke();
        check("R9 poke wins irq", 32'(irq), 32'd0);
        check("R9 poke wins count", 32'(count), 32'd256);
        step(period(1) - 1);
        check("R9 full period later, early", 32'(irq), 32'd0);
        step(1);
        check("R9 full period later", 32'(irq), 32'd1);

        // R10: configuration write and poke on the same edge
        write_cfg(1, 3);
        step(7);
        cfg_wr = 1'b1; cfg_len = 16'd3; cfg_mode = 2'd3; poke = 1'b1;
        step(1);
        cfg_wr = 1'b0; poke = 1'b0;
        check("R10 new length wins", 32'(count), 32'd768);

        // R7: disable via all-zero write after escalation
        write_cfg(1, 3);
        step(period(1));
        check("R7 irq before disable", 32'(irq), 32'd1);
        write_cfg(0, 0);
        check("R7 disabled outputs", 32'({irq, nmi, srst}), 32'd0);
        step(4 * period(1));
        check("R7 disabled stays quiet", 32'({irq, nmi, srst}), 32'd0);
        check("R7 disabled count", 32'(count), 32'd0);

        // R7: mode 0 with nonzero length holds the count
        write_cfg(1, 0);
        step(4 * period(1));
        check("R7 mode0 count held", 32'(count), 32'd256);
        check("R7 mode0 quiet", 32'({irq, nmi, srst}), 32'd0);

        // R7: length 0 with mode 3 stays stopped
        write_cfg(0, 3);
        step(4 * period(1));
        check("R7 len0 quiet", 32'({irq, nmi, srst}), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule